// File: doc/BRIEF.md
# Multi-Hart Run Control Aggregator

This block sits between a debug host and a small cluster of processor harts. It keeps, for each hart, a held halt request, a one-shot resume request with its acknowledge flag, a reset-seen flag and a sticky halt-on-reset request. It drives halt, resume, reset and halt-on-reset levels to every hart.

The host talks to the block through a simple register port with three registers. The control register (address 0) names one hart by a 20-bit index and can widen the selection with a mask-enable flag. The mask register (address 2) lists extra harts. The status register (address 1) reports each hart condition twice: once as "any selected hart" and once as "every selected hart".

Every control write acts on the selection carried in that same write. The stored selection, which the status register uses, then takes the new value.

Top module: `hart_runctl_agg`

## Requirements
- R1: The status register (address 1) holds six any/all pairs. The "any" bit is at even position 2c and the "all" bit at 2c+1. The conditions are c=0 halted, c=1 running, c=2 unavailable, c=3 nonexistent, c=4 resume-acknowledged and c=5 reset-seen. "Any" is 1 when at least one selected hart meets the condition. "All" is 1 only when every selected hart meets it. Bits 31:12 read 0.
- R2: With mask-enable (control bit 26) at 0, only the indexed hart is selected. With it at 1, the selection is the indexed hart plus every hart whose bit is set in the mask register (address 2, bit i for hart i).
- R3: A control write acts on the harts selected by the index and mask-enable values in that same write, not on the previously stored ones.
- R4: Writing the control register loads halt request (bit 31) into the halt output of each selected hart. The level is held, and a later write with bit 31 at 0 clears it only for the harts that write selects.
- R5: Writing resume (bit 30) as 1 raises the resume output and clears the resume-acknowledged flag only for selected harts that are halted at that moment. The resume is ignored when bit 31 is 1 in the same write. A hart's resume acknowledge input drops its resume output and sets its resume-acknowledged flag.
- R6: A hart's reset-seen input pulse sets its reset-seen flag. A control write with bit 28 at 1 clears the flag for the selected harts. With bit 28 at 0, the flag is left unchanged.
- R7: Control bit 3 sets and bit 2 clears the halt-on-reset output of the selected harts. The output stays set until it is cleared. When both bits are 1 in one write, clear wins.
- R8: The hart index has two parts. Its low 10 bits sit at control bits 25:16 and its high 10 bits at bits 15:6, and both read back in the same places. An index at or beyond the number of harts counts as a nonexistent selected hart. It sets both nonexistent bits when nothing else is selected, and a write never acts on it.
- R9: When the block is built without a mask register, mask-enable reads back 0, the mask register reads 0 and writes to it have no effect on the selection.
- R10: Control bit 29 is loaded into the reset output of each selected hart.
- R11: After reset, all hart outputs and all per-hart flags are 0, and the control register reads 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | ADDR_W | Read address |
| reg_rdata | output | 32 | Read data, combinational |
| hart_halted | input | NUM_HARTS | Hart is halted |
| hart_running | input | NUM_HARTS | Hart is running |
| hart_unavail | input | NUM_HARTS | Hart is unavailable |
| hart_resume_ack | input | NUM_HARTS | Hart has taken its resume request |
| hart_reset_seen | input | NUM_HARTS | Pulse: hart went through reset |
| halt_req | output | NUM_HARTS | Held halt request per hart |
| resume_req | output | NUM_HARTS | Pending resume per hart |
| hart_reset | output | NUM_HARTS | Reset level per hart |
| halt_on_reset | output | NUM_HARTS | Halt on next reset release per hart |

## Verification
The bench builds two instances with four harts, one with the mask register and one without, and drives both with the same register traffic. Four harts make room for several selection shapes: a single hart, an index plus mask bits, and indexes beyond the last hart (including one reached only through the high index field). The maskless copy shows that mask-enable and mask writes are inert there. Halted, running and unavailable patterns are chosen so that each "any" and "all" bit is seen both set and clear.

// File: rtl/hart_runctl_agg.sv
module hart_runctl_agg #(
  parameter int NUM_HARTS = 4,
  parameter bit HAS_MASK  = 1'b1,
  parameter int ADDR_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_waddr,
  input  logic [31:0]          reg_wdata,
  input  logic [ADDR_W-1:0]    reg_raddr,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_HARTS-1:0] hart_halted,
  input  logic [NUM_HARTS-1:0] hart_running,
  input  logic [NUM_HARTS-1:0] hart_unavail,
  input  logic [NUM_HARTS-1:0] hart_resume_ack,
  input  logic [NUM_HARTS-1:0] hart_reset_seen,
  output logic [NUM_HARTS-1:0] halt_req,
  output logic [NUM_HARTS-1:0] resume_req,
  output logic [NUM_HARTS-1:0] hart_reset,
  output logic [NUM_HARTS-1:0] halt_on_reset
);
  localparam int IDX_W  = 20;
  localparam int NCOND  = 6;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(2);

  logic [IDX_W-1:0]     idx_q;
  logic                 men_q;
  logic [NUM_HARTS-1:0] mask_q, rack_q, hrst_q;
  logic [NUM_HARTS-1:0] sel, wsel;

  wire              ctrl_wr = reg_wr && (reg_waddr == A_CTRL);
  wire              mask_wr = reg_wr && (reg_waddr == A_MASK);
  wire [IDX_W-1:0]  w_idx   = {reg_wdata[15:6], reg_wdata[25:16]};
  wire              w_men   = HAS_MASK && reg_wdata[26];
  wire              w_halt  = reg_wdata[31];
  wire              w_res   = reg_wdata[30];
  wire              w_rst   = reg_wdata[29];
  wire              w_ack   = reg_wdata[28];
  wire              w_seth  = reg_wdata[3];
  wire              w_clrh  = reg_wdata[2];
  wire              idx_oob = idx_q >= IDX_W'(NUM_HARTS);

  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_sel
    assign sel[i]  = (idx_q == IDX_W'(i)) | (men_q & mask_q[i]);
    assign wsel[i] = (w_idx == IDX_W'(i)) | (w_men & mask_q[i]);
  end

  logic [NUM_HARTS-1:0] cond [NCOND];
  assign cond[0] = hart_halted;
  assign cond[1] = hart_running;
  assign cond[2] = hart_unavail;
  assign cond[3] = '0;
  assign cond[4] = rack_q;
  assign cond[5] = hrst_q;

  logic [NCOND-1:0] st_any, st_all;
  for (genvar c = 0; c < NCOND; c++) begin : g_sum
    localparam bit OOB_VAL = (c == 3);
    assign st_any[c] = (|(sel & cond[c])) | (idx_oob & OOB_VAL);
    assign st_all[c] = (&(~sel | cond[c])) & (~idx_oob | OOB_VAL);
  end

  logic [31:0] stat_word;
  always_comb begin
    stat_word = '0;
    for (int c = 0; c < NCOND; c++) begin
      stat_word[2*c]   = st_any[c];
      stat_word[2*c+1] = st_all[c];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      A_CTRL: begin
        reg_rdata[25:16] = idx_q[9:0];
        reg_rdata[15:6]  = idx_q[19:10];
        reg_rdata[26]    = men_q;
      end
      A_STAT: reg_rdata = stat_word;
      A_MASK: reg_rdata[NUM_HARTS-1:0] = mask_q;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      men_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      if (ctrl_wr) begin
        idx_q <= w_idx;
        men_q <= w_men;
      end
      if (mask_wr && HAS_MASK) mask_q <= reg_wdata[NUM_HARTS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_req      <= '0;
      resume_req    <= '0;
      hart_reset    <= '0;
      halt_on_reset <= '0;
      rack_q        <= '0;
      hrst_q        <= '0;
    end else begin
      for (int i = 0; i < NUM_HARTS; i++) begin
        if (hart_resume_ack[i] && resume_req[i]) begin
          resume_req[i] <= 1'b0;
          rack_q[i]     <= 1'b1;
        end
        if (hart_reset_seen[i]) hrst_q[i] <= 1'b1;
        else if (ctrl_wr && wsel[i] && w_ack) hrst_q[i] <= 1'b0;
        if (ctrl_wr && wsel[i]) begin
          halt_req[i]   <= w_halt;
          hart_reset[i] <= w_rst;
          if (w_res && !w_halt && hart_halted[i]) begin
            resume_req[i] <= 1'b1;
            rack_q[i]     <= 1'b0;
          end
          if (w_clrh)      halt_on_reset[i] <= 1'b0;
          else if (w_seth) halt_on_reset[i] <= 1'b1;
        end
      end
    end
  end

  AST_ALL_NEEDS_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_all & ~st_any) == '0); // R1
  AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !men_q |-> $countones(sel) <= 1); // R2
  AST_HALT_BLOCKS_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && w_halt) |=> (resume_req & ~$past(resume_req)) == '0); // R5
  AST_RESUME_ONLY_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_req & ~$past(resume_req) & ~$past(hart_halted)) == '0); // R5
  AST_ACK_CLEARS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && w_ack && hart_reset_seen == '0) |=> (hrst_q & $past(wsel)) == '0); // R6
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && w_clrh) |=> (halt_on_reset & $past(wsel)) == '0); // R7
endmodule

// File: tb/hart_runctl_agg_bench.sv
module hart_runctl_agg_bench;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_waddr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata_m, rdata_n;
  logic [N-1:0] halted = '0, running = '0, unavail = '0, rack = '0, rseen = '0;
  logic [N-1:0] hreq_m, rreq_m, hrst_m, hor_m, hreq_n, rreq_n, hrst_n, hor_n;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  hart_runctl_agg #(.NUM_HARTS(N), .HAS_MASK(1'b1), .ADDR_W(2)) u_hart_runctl_agg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(rdata_m), .hart_halted(halted), .hart_running(running),
    .hart_unavail(unavail), .hart_resume_ack(rack), .hart_reset_seen(rseen),
    .halt_req(hreq_m), .resume_req(rreq_m), .hart_reset(hrst_m), .halt_on_reset(hor_m));

  hart_runctl_agg #(.NUM_HARTS(N), .HAS_MASK(1'b0), .ADDR_W(2)) u_nomask (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(rdata_n), .hart_halted(halted), .hart_running(running),
    .hart_unavail(unavail), .hart_resume_ack(rack), .hart_reset_seen(rseen),
    .halt_req(hreq_n), .resume_req(rreq_n), .hart_reset(hrst_n), .halt_on_reset(hor_n));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input bit halt, input bit res, input bit rst, input bit ack,
                                     input bit men, input logic [19:0] idx, input bit seth, input bit clrh);
    logic [31:0] w = '0;
    w[31] = halt; w[30] = res; w[29] = rst; w[28] = ack; w[26] = men;
    w[25:16] = idx[9:0]; w[15:6] = idx[19:10]; w[3] = seth; w[2] = clrh;
    return w;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_m(input logic [1:0] a, output logic [31:0] v);
    reg_raddr = a; #1; v = rdata_m;
  endtask

  task automatic rd_n(input logic [1:0] a, output logic [31:0] v);
    reg_raddr = a; #1; v = rdata_n;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd_m(2'd1, v); check("R11 status", v, 32'h0);
    rd_m(2'd0, v); check("R11 ctrl", v, 32'h0);
    check("R11 outputs", {16'h0, hreq_m, rreq_m, hrst_m, hor_m}, 32'h0);
  endtask

  task automatic t_halt;
    wr(2'd2, 32'h9);
    wr(2'd0, cw(1,0,0,0,0,20'd2,0,0)); check("R4 halt one", 32'(hreq_m), 32'h4);
    wr(2'd0, cw(1,0,0,0,1,20'd2,0,0)); check("R2 halt masked", 32'(hreq_m), 32'hD);
    wr(2'd0, cw(0,0,0,0,0,20'd0,0,0)); check("R3 new selection", 32'(hreq_m), 32'hC);
    wr(2'd0, cw(0,0,0,0,1,20'd2,0,0)); check("R4 cleared", 32'(hreq_m), 32'h0);
  endtask

  task automatic t_summary;
    logic [31:0] v;
    halted = 4'b1101; running = 4'b0010;
    wr(2'd0, cw(0,0,0,0,1,20'd2,0,0));
    rd_m(2'd1, v); check("R1 all halted", v, 32'h3);
    halted = 4'b0101;
    rd_m(2'd1, v); check("R1 some halted", v, 32'h1);
    wr(2'd0, cw(0,0,0,0,0,20'd1,0,0));
    rd_m(2'd1, v); check("R2 single running", v, 32'hC);
    unavail = 4'b0010;
    rd_m(2'd1, v); check("R1 unavail", v, 32'h3C);
    halted = '0; running = '0; unavail = '0;
  endtask

  task automatic t_index;
    logic [31:0] v;
    wr(2'd0, cw(1,0,0,0,0,20'd5,0,0));
    rd_m(2'd1, v); check("R8 oob status", v, 32'hC0);
    check("R8 oob no effect", 32'(hreq_m), 32'h0);
    rd_m(2'd0, v); check("R8 readback lo", v, 32'h0005_0000);
    wr(2'd0, cw(0,0,0,0,1,20'd5,0,0));
    rd_m(2'd1, v); check("R8 oob plus mask", v, 32'h40);
    wr(2'd0, cw(0,0,0,0,0,20'h00401,0,0));
    rd_m(2'd0, v); check("R8 split fields", v, 32'h0001_0040);
    rd_m(2'd1, v); check("R8 high part oob", v, 32'hC0);
  endtask

  task automatic t_resume;
    logic [31:0] v;
    halted = 4'b0001; wr(2'd2, 32'h3);
    wr(2'd0, cw(0,1,0,0,1,20'd0,0,0));
    check("R5 resume halted only", 32'(rreq_m), 32'h1);
    rd_m(2'd1, v); check("R5 ack cleared", v & 32'h300, 32'h0);
    @(negedge clk); rack = 4'b0001; @(negedge clk); rack = '0;
    check("R5 resume dropped", 32'(rreq_m), 32'h0);
    rd_m(2'd1, v); check("R1 ack any not all", v & 32'h300, 32'h100);
    wr(2'd0, cw(0,0,0,0,0,20'd0,0,0));
    rd_m(2'd1, v); check("R1 ack all", v & 32'h300, 32'h300);
    wr(2'd0, cw(1,1,0,0,0,20'd0,0,0));
    check("R5 ignored with halt", 32'(rreq_m), 32'h0);
    rd_m(2'd1, v); check("R5 ack kept", v & 32'h300, 32'h300);
    wr(2'd0, cw(0,0,0,0,0,20'd0,0,0));
    halted = '0;
  endtask

  task automatic t_havereset;
    logic [31:0] v;
    @(negedge clk); rseen = 4'b0110; @(negedge clk); rseen = '0;
    wr(2'd0, cw(0,0,0,0,0,20'd1,0,0));
    rd_m(2'd1, v); check("R6 seen set", v & 32'hC00, 32'hC00);
    wr(2'd0, cw(0,0,0,0,1,20'd1,0,0));
    rd_m(2'd1, v); check("R1 seen any only", v & 32'hC00, 32'h400);
    wr(2'd0, cw(0,0,0,0,0,20'd1,0,0));
    rd_m(2'd1, v); check("R6 ack zero no effect", v & 32'hC00, 32'hC00);
    wr(2'd0, cw(0,0,0,1,0,20'd1,0,0));
    rd_m(2'd1, v); check("R6 ack clears", v & 32'hC00, 32'h0);
    wr(2'd0, cw(0,0,0,0,0,20'd2,0,0));
    rd_m(2'd1, v); check("R6 other kept", v & 32'hC00, 32'hC00);
  endtask

  task automatic t_hor;
    wr(2'd0, cw(0,0,0,0,0,20'd3,1,0)); check("R7 set", 32'(hor_m), 32'h8);
    wr(2'd0, cw(0,0,0,0,0,20'd3,1,1)); check("R7 clear wins", 32'(hor_m), 32'h0);
    wr(2'd0, cw(0,0,0,0,1,20'd0,1,0)); check("R7 set masked", 32'(hor_m), 32'h3);
    wr(2'd0, cw(0,0,0,0,0,20'd0,0,0)); check("R7 sticky", 32'(hor_m), 32'h3);
    wr(2'd0, cw(0,0,0,0,0,20'd1,0,1)); check("R7 clear one", 32'(hor_m), 32'h1);
  endtask

  task automatic t_hartreset;
    wr(2'd0, cw(0,0,1,0,0,20'd1,0,0)); check("R10 reset on", 32'(hrst_m), 32'h2);
    wr(2'd0, cw(0,0,0,0,0,20'd1,0,0)); check("R10 reset off", 32'(hrst_m), 32'h0);
  endtask

  task automatic t_nomask;
    logic [31:0] v;
    wr(2'd2, 32'hF);
    wr(2'd0, cw(1,0,0,0,1,20'd0,0,0));
    check("R9 single hart", 32'(hreq_n), 32'h1);
    check("R2 masked halt", 32'(hreq_m), 32'hF);
    rd_n(2'd0, v); check("R9 mask-enable reads 0", v & 32'h0400_0000, 32'h0);
    rd_m(2'd0, v); check("R2 mask-enable reads 1", v & 32'h0400_0000, 32'h0400_0000);
    rd_n(2'd2, v); check("R9 mask reads 0", v, 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_halt();
    t_summary();
    t_index();
    t_resume();
    t_havereset();
    t_hor();
    t_hartreset();
    t_nomask();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule